// File: doc/BRIEF.md
# Dual Data Pointer Control Unit

This block keeps the two 16-bit data pointers of an 8051-class core together with the 8-bit control register that manages them. One bit of the control register selects which pointer is active. The core's decoder sends the block one strobe per pointer-related instruction: pointer increment, immediate pointer load, code read through the pointer, external data read and external data write. The block updates the active pointer, and the active pointer's value is always presented on its output.

Two optional behaviours are controlled by enable bits in the control register. With the toggle enable set, the select bit flips after each of the five pointer instructions. With the adjust enable set, the three memory-access instructions step the active pointer by one afterwards. A separate direction bit for each pointer chooses whether that step is an increment or a decrement. Software writes the whole control register through a dedicated write port and reads it back on `ctl_out`.

Top module: `dual_dptr_unit`

## Requirements
- R1: A synchronous reset (`rst` high) clears both pointers and the control register to zero. Pointer 0 is then active, and `ptr_out` and `ctl_out` read zero.
- R2: Control bit 0 is the select bit: 0 makes pointer 0 active and 1 makes pointer 1 active. `ptr_out` shows the active pointer and `ctl_out` shows the control register. Both outputs are registered and show the result of a clock edge right after that edge.
- R3: `op_load` writes `load_val` into the active pointer.
- R4: `op_inc` adds 1 to the active pointer, modulo 2^16. It always increments, whatever the adjust-enable and direction bits hold.
- R5: When control bit 4 (adjust enable) is 1, each of `op_code_rd`, `op_xrd` and `op_xwr` steps the active pointer by one. When bit 4 is 0, these strobes leave both pointers unchanged.
- R6: Control bit 6 sets the step direction for pointer 0 and bit 7 sets it for pointer 1 (0 = increment, 1 = decrement). The step wraps modulo 2^16.
- R7: When control bit 5 (toggle enable) is 1, any of the five strobes inverts the select bit. When bit 5 is 0, the select bit changes only through a control write.
- R8: When both enables are set, a memory-access strobe adjusts the pointer that was active during that instruction, and the select bit then toggles.
- R9: `ctl_we` loads all 8 bits of `ctl_wdata` into the control register and overrides an automatic toggle in the same cycle. A strobe in that cycle still acts on its pointer using the control value held before the write.
- R10: No strobe changes the pointer that is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_inc | input | 1 | Pointer-increment instruction strobe |
| op_load | input | 1 | Immediate pointer-load instruction strobe |
| op_code_rd | input | 1 | Code read through pointer strobe |
| op_xrd | input | 1 | External data read through pointer strobe |
| op_xwr | input | 1 | External data write through pointer strobe |
| load_val | input | 16 | Immediate value for `op_load` |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| ptr_out | output | 16 | Value of the active pointer |
| ctl_out | output | 8 | Control register readback |

## Verification
Every result is due exactly one clock edge after its stimulus. A strobe or a control write presented before an edge is visible on `ptr_out` and `ctl_out` right after that edge, so a toggled select shows the other pointer in that same cycle. The bench drives inputs on the falling edge and compares the outputs on the next falling edge, half a cycle after the rising edge that registers them. The checker's properties use `|=>`, so each one compares the outputs one edge after its antecedent.

// File: rtl/dual_dptr_pkg.sv
package dual_dptr_pkg;
  localparam int SEL_POS    = 0;
  localparam int ADJ_EN_POS = 4;
  localparam int TGL_EN_POS = 5;
  localparam int DIR0_POS   = 6;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_LOAD,
    ACT_STEP_UP,
    ACT_ADJUST
  } ptr_act_e;
endpackage

// File: rtl/dual_dptr_cell.sv
module dual_dptr_cell
  import dual_dptr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ptr_act_e         act,
  input  logic             dec,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] val,
  output logic [PTR_W-1:0] nxt
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_comb begin
    case (act)
      ACT_LOAD:    nxt = load_val;
      ACT_STEP_UP: nxt = val + ONE;
      ACT_ADJUST:  nxt = dec ? (val - ONE) : (val + ONE);
      default:     nxt = val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) val <= '0;
    else     val <= nxt;
  end
endmodule

// File: rtl/dual_dptr_decode.sv
module dual_dptr_decode
  import dual_dptr_pkg::*;
#(
  parameter int NUM_PTR = 2
) (
  input  logic     op_inc,
  input  logic     op_load,
  input  logic     op_code_rd,
  input  logic     op_xrd,
  input  logic     op_xwr,
  input  logic     sel,
  input  logic     adj_en,
  input  logic     tgl_en,
  output ptr_act_e act [NUM_PTR],
  output logic     toggle_evt
);
  logic mem_op;
  logic any_op;

  assign mem_op     = op_code_rd | op_xrd | op_xwr;
  assign any_op     = mem_op | op_inc | op_load;
  assign toggle_evt = tgl_en & any_op;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_act
    always_comb begin
      act[i] = ACT_NONE;
      if (sel == 1'(i)) begin
        if (op_load)               act[i] = ACT_LOAD;
        else if (op_inc)           act[i] = ACT_STEP_UP;
        else if (mem_op && adj_en) act[i] = ACT_ADJUST;
      end
    end
  end
endmodule

// File: rtl/dual_dptr_ctl.sv
module dual_dptr_ctl
  import dual_dptr_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             toggle_evt,
  output logic [CTL_W-1:0] ctl,
  output logic [CTL_W-1:0] nxt
);
  localparam logic [CTL_W-1:0] SEL_MASK = CTL_W'(1) << SEL_POS;

  always_comb begin
    if (we)              nxt = wdata;
    else if (toggle_evt) nxt = ctl ^ SEL_MASK;
    else                 nxt = ctl;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else     ctl <= nxt;
  end
endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dual_dptr_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_inc,
  input  logic             op_load,
  input  logic             op_code_rd,
  input  logic             op_xrd,
  input  logic             op_xwr,
  input  logic [PTR_W-1:0] load_val,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [PTR_W-1:0] ptr_out,
  output logic [CTL_W-1:0] ctl_out
);
  localparam int NUM_PTR = 2;

  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_nxt;
  logic             toggle_evt;
  ptr_act_e         act [NUM_PTR];
  logic [PTR_W-1:0] ptr_val [NUM_PTR];
  logic [PTR_W-1:0] ptr_nxt [NUM_PTR];

  dual_dptr_decode #(.NUM_PTR(NUM_PTR)) u_decode (
    .op_inc     (op_inc),
    .op_load    (op_load),
    .op_code_rd (op_code_rd),
    .op_xrd     (op_xrd),
    .op_xwr     (op_xwr),
    .sel        (ctl_q[SEL_POS]),
    .adj_en     (ctl_q[ADJ_EN_POS]),
    .tgl_en     (ctl_q[TGL_EN_POS]),
    .act        (act),
    .toggle_evt (toggle_evt)
  );

  dual_dptr_ctl #(.CTL_W(CTL_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .we         (ctl_we),
    .wdata      (ctl_wdata),
    .toggle_evt (toggle_evt),
    .ctl        (ctl_q),
    .nxt        (ctl_nxt)
  );

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    dual_dptr_cell #(.PTR_W(PTR_W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .act      (act[i]),
      .dec      (ctl_q[DIR0_POS + i]),
      .load_val (load_val),
      .val      (ptr_val[i]),
      .nxt      (ptr_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_out <= '0;
    else     ptr_out <= ptr_nxt[ctl_nxt[SEL_POS]];
  end

  assign ctl_out = ctl_q;
endmodule

// File: rtl/dual_dptr_chk.sv
module dual_dptr_chk #(
  parameter int PTR_W = 16,
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_inc,
  input logic             op_load,
  input logic             op_code_rd,
  input logic             op_xrd,
  input logic             op_xwr,
  input logic [PTR_W-1:0] load_val,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [PTR_W-1:0] ptr_out,
  input logic [CTL_W-1:0] ctl_out
);
  logic any_op;
  assign any_op = op_inc | op_load | op_code_rd | op_xrd | op_xwr;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ptr_out == '0 && ctl_out == '0)); // R1

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> ctl_out == $past(ctl_wdata)); // R9

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (!ctl_we && any_op && ctl_out[5]) |=> ctl_out[0] != $past(ctl_out[0])); // R7

  AST_CTL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctl_we && !(any_op && ctl_out[5])) |=> $stable(ctl_out)); // R7

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (op_load && !ctl_we && !ctl_out[5]) |=> ptr_out == $past(load_val)); // R3

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (op_inc && !op_load && !ctl_we && !ctl_out[5])
      |=> ptr_out == $past(ptr_out) + PTR_W'(1)); // R4

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!any_op && !ctl_we) |=> $stable(ptr_out)); // R2
endmodule

bind dual_dptr_unit dual_dptr_chk #(.PTR_W(PTR_W), .CTL_W(CTL_W)) u_chk (.*);

// File: tb/tb_dual_dptr_unit.sv
module tb_dual_dptr_unit;
  localparam int VW = 52;
  localparam int NV = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_inc = 0, op_load = 0, op_code_rd = 0, op_xrd = 0, op_xwr = 0;
  logic [15:0] load_val = '0;
  logic        ctl_we = 0;
  logic [7:0]  ctl_wdata = '0;
  logic [15:0] ptr_out;
  logic [7:0]  ctl_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_dptr_unit dut (.*);

  // Vector: {we, wdata, op, load_val, exp_ptr, exp_ctl}
  // op: 0 none, 1 load, 2 inc, 3 code read, 4 data read, 5 data write
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 8'h00, 3'd1, 16'h1234, 16'h1234, 8'h00}, // R3 load p0
    {1'b0, 8'h00, 3'd2, 16'h0000, 16'h1235, 8'h00}, // R4 inc
    {1'b0, 8'h00, 3'd4, 16'h0000, 16'h1235, 8'h00}, // R5 adjust off
    {1'b1, 8'h01, 3'd0, 16'h0000, 16'h0000, 8'h01}, // R2 select p1
    {1'b0, 8'h00, 3'd1, 16'hFFFF, 16'hFFFF, 8'h01}, // R3 load p1
    {1'b0, 8'h00, 3'd2, 16'h0000, 16'h0000, 8'h01}, // R4 wrap
    {1'b1, 8'h11, 3'd0, 16'h0000, 16'h0000, 8'h11}, // R5 enable adjust
    {1'b0, 8'h00, 3'd5, 16'h0000, 16'h0001, 8'h11}, // R5 write steps up
    {1'b1, 8'h91, 3'd0, 16'h0000, 16'h0001, 8'h91}, // R6 p1 decrement
    {1'b0, 8'h00, 3'd3, 16'h0000, 16'h0000, 8'h91}, // R6 code read dec
    {1'b0, 8'h00, 3'd4, 16'h0000, 16'hFFFF, 8'h91}, // R6 dec wraps
    {1'b1, 8'h90, 3'd0, 16'h0000, 16'h1235, 8'h90}, // R10 p0 untouched
    {1'b0, 8'h00, 3'd4, 16'h0000, 16'h1236, 8'h90}, // R6 p0 increments
    {1'b1, 8'hD0, 3'd0, 16'h0000, 16'h1236, 8'hD0}, // R6 p0 decrement set
    {1'b0, 8'h00, 3'd5, 16'h0000, 16'h1235, 8'hD0}, // R6 p0 decrements
    {1'b0, 8'h00, 3'd2, 16'h0000, 16'h1236, 8'hD0}, // R4 inc ignores dir
    {1'b1, 8'h20, 3'd0, 16'h0000, 16'h1236, 8'h20}, // R7 toggle only
    {1'b0, 8'h00, 3'd1, 16'hABCD, 16'hFFFF, 8'h21}, // R7 load then flip
    {1'b0, 8'h00, 3'd2, 16'h0000, 16'hABCD, 8'h20}, // R7 inc then flip
    {1'b0, 8'h00, 3'd0, 16'h0000, 16'hABCD, 8'h20}, // R2 idle holds
    {1'b1, 8'h30, 3'd0, 16'h0000, 16'hABCD, 8'h30}, // R8 both enables
    {1'b0, 8'h00, 3'd3, 16'h0000, 16'h0000, 8'h31}, // R8 p0 adj, flip
    {1'b0, 8'h00, 3'd5, 16'h0000, 16'hABCE, 8'h30}, // R8 p1 adj, flip
    {1'b1, 8'h70, 3'd4, 16'h0000, 16'hABCF, 8'h70}, // R9 write beats toggle
    {1'b1, 8'h71, 3'd0, 16'h0000, 16'h0001, 8'h71}  // R10 p1 kept
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_ops();
    {op_inc, op_load, op_code_rd, op_xrd, op_xwr, ctl_we} = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ptr after reset", ptr_out, 16'h0000);
    check("R1 ctl after reset", {8'h00, ctl_out}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      logic [2:0]    op;
      v = VEC[i];
      op = v[42:40];
      clear_ops();
      ctl_we    = v[51];
      ctl_wdata = v[50:43];
      load_val  = v[39:24];
      op_load    = (op == 3'd1);
      op_inc     = (op == 3'd2);
      op_code_rd = (op == 3'd3);
      op_xrd     = (op == 3'd4);
      op_xwr     = (op == 3'd5);
      @(negedge clk);
      check($sformatf("vector %0d ptr", i), ptr_out, v[23:8]);
      check($sformatf("vector %0d ctl", i), {8'h00, ctl_out}, {8'h00, v[7:0]});
    end
    clear_ops();

    // R1: reset in mid run clears both pointers and the control register
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 ptr mid-run reset", ptr_out, 16'h0000);
    check("R1 ctl mid-run reset", {8'h00, ctl_out}, 16'h0000);
    ctl_we = 1'b1; ctl_wdata = 8'h01;
    @(negedge clk);
    clear_ops();
    check("R1 p1 cleared", ptr_out, 16'h0000);

    // R5: adjust disabled, data write leaves p1 alone
    op_xwr = 1'b1;
    @(negedge clk);
    clear_ops();
    check("R5 no adjust when disabled", ptr_out, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule